// File: doc/BRIEF.md
# CPU Address Window Decoder

This block sits between a CPU address bus and two downstream PCI buses and decides which programmable window, if any, a CPU address falls into. There are eleven windows in all. Each downstream bus has one I/O window and four memory windows, and one further window covers the chip's internal register space. For a hit, the block returns the index of the window and the downstream address the access should carry.

Software sets the windows through a simple 32-bit register port. Each window has a base, a size and a remap setting, and one shared enable vector gates all of them. The lookup port is purely combinational. It takes a 36-bit CPU address and presents the hit flag, the window index and a 64-bit translated address in the same cycle. Register writes take effect at the next rising clock edge.

Top module: `cpu_win_decoder`

## Requirements
- R1: Register word addresses are as follows. For window w, the base register is at 4w, the size register at 4w+1, the low remap register at 4w+2 and the high remap register at 4w+3. The enable register is at 0x2C and the configuration register at 0x2D. Reads are combinational, and any other address reads 0.
- R2: The enable register holds 21 bits and reads back as written. A window is active only while its enable bit is 0. Windows 0–4 use bits 9–13, windows 5–9 use bits 14–18, and window 10 uses bit 20. A lookup never reports a window whose bit is 1.
- R3: After reset, every base, size and remap register reads 0 and the enable register reads 0x0FBFFF. With those values, window 5 and window 10 are the only active windows.
- R4: A base write is masked before it is stored. I/O windows (0 and 5) keep the bits in 0x030FFFFF, memory windows (1–4 and 6–9) keep the bits in 0x070FFFFF, and window 10 keeps the bits in 0x000FFFFF. Bits 19:0 are the base field, and bits 25:24 are a stored data-swap field whose only meaningful value is 01.
- R5: A size write keeps only its 16 low bits. A window starts at base field × 65536 and covers (size + 1) × 65536 bytes.
- R6: On a hit in a memory window, the translated address is {high remap[31:0], low remap[15:0], 16'h0} plus the CPU address minus the window start.
- R7: A write to the base register of windows 0–9 also loads the low remap with the written value's bits 15:0. This happens only while configuration bit 27 is 0. Configuration bit 27 reads back at bit 27.
- R8: I/O windows have no high remap. Writes to it are ignored and it reads 0. Their translated address is {32'h0, low remap, 16'h0} plus the offset.
- R9: Window 10 always covers 64 KiB. Its size and remap registers ignore writes and read 0. Its translated address is the offset from its start.
- R10: When more than one active window contains the address, the lowest index wins.
- R11: A lookup that hits no active window returns hit = 0, index = 4'hF and a translated address of 0.
- R12: Windows decode all 36 address bits, so a window placed above 4 GiB is not hit by the same address with bit 32 and above cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lk_addr | input | 36 | CPU address to decode |
| lk_hit | output | 1 | Address falls in an active window |
| lk_idx | output | 4 | Winning window index, 4'hF on a miss |
| lk_daddr | output | 64 | Translated downstream address |

## Verification
The bench probes both ends of a memory window: the first byte, the last byte, one byte past the end and one byte before the start. A design that mishandles the size-plus-one rule would lose the last 64 KiB or gain an extra 64 KiB. It places two windows over the same range and then disables the lower one, which catches a priority encoder that favours the higher index or a decoder that ignores the active-low enable sense. It also covers the base-to-remap copy with the configuration bit both clear and set, the masks on reads of the base registers, the missing high remap on I/O windows, and a window above 4 GiB. A decoder that keeps only 32 bits would hit on the aliased low address.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  typedef enum logic [1:0] {
    WK_IO   = 2'd0,
    WK_MEM  = 2'd1,
    WK_REGS = 2'd2
  } win_kind_e;

  typedef struct packed {
    logic [26:0] base;
    logic [15:0] size;
    logic [15:0] rlo;
    logic [31:0] rhi;
  } win_cfg_t;

  // The last window is the register window; each bus group opens with its I/O window.
  function automatic win_kind_e kind_of(int w, int per_bus, int nwin);
    if (w == nwin - 1)            return WK_REGS;
    else if (w % (per_bus + 1) == 0) return WK_IO;
    else                          return WK_MEM;
  endfunction

  function automatic logic [31:0] base_mask(win_kind_e k);
    case (k)
      WK_IO:   return 32'h030F_FFFF;
      WK_MEM:  return 32'h070F_FFFF;
      default: return 32'h000F_FFFF;
    endcase
  endfunction

  function automatic int en_bit(int w, int nwin, int first, int regbit);
    return (w == nwin - 1) ? regbit : first + w;
  endfunction

endpackage

// File: rtl/cwd_regs.sv
module cwd_regs
  import cwd_pkg::*;
#(
  parameter int NUM_WIN     = 11,
  parameter int MEM_PER_BUS = 4,
  parameter int EN_W        = 21,
  parameter int AW          = 8,
  parameter logic [EN_W-1:0] EN_RST = 21'h0F_BFFF,
  parameter int CFG_BIT     = 27
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output win_cfg_t        win_o [NUM_WIN],
  output logic [EN_W-1:0] en_o
);

  localparam int ADDR_EN  = 4 * NUM_WIN;
  localparam int ADDR_CFG = ADDR_EN + 1;

  win_cfg_t        win_q [NUM_WIN];
  win_cfg_t        win_d [NUM_WIN];
  logic [EN_W-1:0] en_q, en_d;
  logic            noremap_q, noremap_d;

  // next state
  always_comb begin
    for (int w = 0; w < NUM_WIN; w++) win_d[w] = win_q[w];
    en_d      = en_q;
    noremap_d = noremap_q;
    if (int'(reg_addr) == ADDR_EN) begin
      en_d = reg_wdata[EN_W-1:0];
    end else if (int'(reg_addr) == ADDR_CFG) begin
      noremap_d = reg_wdata[CFG_BIT];
    end else begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (int'(reg_addr[AW-1:2]) == w) begin
          case (reg_addr[1:0])
            2'd0: begin
              win_d[w].base = 27'(reg_wdata & base_mask(kind_of(w, MEM_PER_BUS, NUM_WIN)));
              if (!noremap_q && kind_of(w, MEM_PER_BUS, NUM_WIN) != WK_REGS)
                win_d[w].rlo = reg_wdata[15:0];
            end
            2'd1: if (kind_of(w, MEM_PER_BUS, NUM_WIN) != WK_REGS)
                    win_d[w].size = reg_wdata[15:0];
            2'd2: if (kind_of(w, MEM_PER_BUS, NUM_WIN) != WK_REGS)
                    win_d[w].rlo = reg_wdata[15:0];
            default: if (kind_of(w, MEM_PER_BUS, NUM_WIN) == WK_MEM)
                       win_d[w].rhi = reg_wdata;
          endcase
        end
      end
    end
  end

  // state, write strobe as clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WIN; w++) win_q[w] <= '0;
      en_q      <= EN_RST;
      noremap_q <= 1'b0;
    end else if (reg_we) begin
      for (int w = 0; w < NUM_WIN; w++) win_q[w] <= win_d[w];
      en_q      <= en_d;
      noremap_q <= noremap_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) == ADDR_EN) begin
      reg_rdata = 32'(en_q);
    end else if (int'(reg_addr) == ADDR_CFG) begin
      reg_rdata[CFG_BIT] = noremap_q;
    end else begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (int'(reg_addr[AW-1:2]) == w) begin
          case (reg_addr[1:0])
            2'd0:    reg_rdata = 32'(win_q[w].base);
            2'd1:    reg_rdata = 32'(win_q[w].size);
            2'd2:    reg_rdata = 32'(win_q[w].rlo);
            default: reg_rdata = win_q[w].rhi;
          endcase
        end
      end
    end
  end

  assign win_o = win_q;
  assign en_o  = en_q;

  // R2: enable register takes the written value
  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && int'(reg_addr) == ADDR_EN) |=> (en_q == $past(reg_wdata[EN_W-1:0])));

  // R7: base write loads the low remap while the copy is allowed
  a_r7_base_copies_remap: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0 && !noremap_q) |=> (win_q[0].rlo == $past(reg_wdata[15:0])));

  // R7: base write leaves the low remap alone when the copy is blocked
  a_r7_copy_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0 && noremap_q) |=> $stable(win_q[0].rlo));

endmodule

// File: rtl/cwd_window.sv
module cwd_window
  import cwd_pkg::*;
#(
  parameter int        ADDR_W = 36,
  parameter int        SHIFT  = 16,
  parameter win_kind_e KIND   = WK_MEM
) (
  input  win_cfg_t          cfg,
  input  logic              active,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [63:0]       daddr
);

  localparam int LW = ADDR_W + 1;
  localparam int BF = ADDR_W - SHIFT;

  logic [ADDR_W-1:0] start, offs;
  logic [LW-1:0]     span, stop;
  logic [63:0]       remap;
  logic              unused_base;

  assign unused_base = ^cfg.base[26:BF];

  always_comb begin
    start = {cfg.base[BF-1:0], {SHIFT{1'b0}}};
    if (KIND == WK_REGS) span = LW'(1) << SHIFT;
    else                 span = (LW'(cfg.size) + LW'(1)) << SHIFT;
    stop  = {1'b0, start} + span;
    hit   = active && (addr >= start) && ({1'b0, addr} < stop);
    offs  = addr - start;
    case (KIND)
      WK_IO:   remap = {32'h0, cfg.rlo, 16'h0};
      WK_MEM:  remap = {cfg.rhi, cfg.rlo, 16'h0};
      default: remap = '0;
    endcase
    daddr = remap + 64'(offs);
  end

endmodule

// File: rtl/cwd_select.sv
module cwd_select #(
  parameter int NUM_WIN = 11,
  parameter int IW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_WIN-1:0] hit_vec,
  input  logic [63:0]        daddr_i [NUM_WIN],
  output logic               hit,
  output logic [IW-1:0]      idx,
  output logic [63:0]        daddr
);

  logic [NUM_WIN-1:0] grant, below;

  always_comb begin
    hit   = 1'b0;
    idx   = '1;
    daddr = '0;
    grant = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        hit   = 1'b1;
        idx   = IW'(w);
        daddr = daddr_i[w];
        grant = NUM_WIN'(1) << w;
      end
    end
  end

  always_comb begin
    for (int w = 0; w < NUM_WIN; w++) below[w] = (w < int'(idx));
  end

  // R10: no lower-index window also matches the winner
  a_r10_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((hit_vec & below) == '0));

  a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R11: miss presents the all-ones index and a zero address
  a_r11_miss_output: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (idx == '1 && daddr == '0));

endmodule

// File: rtl/cpu_win_decoder.sv
module cpu_win_decoder
  import cwd_pkg::*;
#(
  parameter int NUM_BUS     = 2,
  parameter int MEM_PER_BUS = 4,
  parameter int ADDR_W      = 36,
  parameter int RA_W        = 8,
  parameter int EN_W        = 21,
  parameter int EN_FIRST    = 9,
  parameter int EN_REGS     = 20,
  parameter int SHIFT       = 16,
  parameter int NUM_WIN     = NUM_BUS * (MEM_PER_BUS + 1) + 1,
  parameter int IW          = $clog2(NUM_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [IW-1:0]     lk_idx,
  output logic [63:0]       lk_daddr
);

  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  win_cfg_t           win [NUM_WIN];
  logic [EN_W-1:0]    en;
  logic [NUM_WIN-1:0] act, hits;
  logic [63:0]        wdaddr [NUM_WIN];

  cwd_regs #(
    .NUM_WIN(NUM_WIN), .MEM_PER_BUS(MEM_PER_BUS), .EN_W(EN_W), .AW(RA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_o(win), .en_o(en)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int EB = en_bit(w, NUM_WIN, EN_FIRST, EN_REGS);
    assign act[w] = ~en[EB];
    cwd_window #(
      .ADDR_W(ADDR_W), .SHIFT(SHIFT), .KIND(kind_of(w, MEM_PER_BUS, NUM_WIN))
    ) u_win (
      .cfg(win[w]), .active(act[w]), .addr(lk_addr),
      .hit(hits[w]), .daddr(wdaddr[w])
    );
  end

  cwd_select #(.NUM_WIN(NUM_WIN), .IW(IW)) u_sel (
    .clk(clk), .rst_n(rst_n_i), .hit_vec(hits), .daddr_i(wdaddr),
    .hit(lk_hit), .idx(lk_idx), .daddr(lk_daddr)
  );

  // enable bit of the reported window, taken straight from the register
  logic idx_enabled;
  always_comb begin
    idx_enabled = 1'b0;
    for (int w = 0; w < NUM_WIN; w++)
      if (int'(lk_idx) == w) idx_enabled = !en[en_bit(w, NUM_WIN, EN_FIRST, EN_REGS)];
  end

  // R2: a reported hit always belongs to a window whose enable bit is clear
  a_r2_hit_is_enabled: assert property (@(posedge clk) disable iff (!rst_n_i)
    lk_hit |-> idx_enabled);

endmodule

// File: tb/cpu_win_decoder_bench.sv
module cpu_win_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [35:0] lk_addr;
  logic        lk_hit;
  logic [3:0]  lk_idx;
  logic [63:0] lk_daddr;

  int errors = 0;
  int checks = 0;

  localparam logic [7:0] A_EN  = 8'h2C;
  localparam logic [7:0] A_CFG = 8'h2D;

  always #2 clk = ~clk;

  cpu_win_decoder u_cpu_win_decoder (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_daddr(lk_daddr)
  );

  function automatic logic [7:0] ra(int w, int k);
    return 8'(4 * w + k);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic look(input string tag, input logic [35:0] a, input logic h,
                      input logic [3:0] i, input logic [63:0] d);
    lk_addr = a;
    #1;
    chk({tag, " hit"}, 64'(lk_hit), 64'(h));
    chk({tag, " idx"}, 64'(lk_idx), 64'(i));
    if (h) chk({tag, " daddr"}, lk_daddr, d);
  endtask

  task automatic t_reset;
    rd_chk("R3 enable reset", A_EN, 32'h000F_BFFF);
    rd_chk("R3 base reset", ra(1, 0), 32'h0);
    rd_chk("R3 remap reset", ra(1, 2), 32'h0);
    rd_chk("R1 unmapped read", 8'h3F, 32'h0);
    // windows 5 and 10 both sit at 0; the lower index wins
    look("R3 R10 reset lookup", 36'h0_0000_1234, 1'b1, 4'd5, 64'h1234);
  endtask

  task automatic t_masks;
    wr(ra(1, 0), 32'hFFFF_FFFF);
    rd_chk("R4 mem base mask", ra(1, 0), 32'h070F_FFFF);
    wr(ra(0, 0), 32'hFFFF_FFFF);
    rd_chk("R4 io base mask", ra(0, 0), 32'h030F_FFFF);
    wr(ra(10, 0), 32'hFFFF_FFFF);
    rd_chk("R4 regs base mask", ra(10, 0), 32'h000F_FFFF);
    wr(ra(1, 1), 32'hFFFF_FFFF);
    rd_chk("R5 size mask", ra(1, 1), 32'h0000_FFFF);
  endtask

  task automatic t_enable;
    wr(A_EN, 32'hFFFF_FFFF);
    rd_chk("R2 enable readback", A_EN, 32'h001F_FFFF);
    look("R2 R11 all disabled", 36'h0_0000_1234, 1'b0, 4'hF, 64'h0);
    chk("R11 miss daddr", lk_daddr, 64'h0);
  endtask

  task automatic t_mem;
    wr(A_CFG, 32'h0);
    wr(A_EN, 32'h001F_FBFF);
    wr(ra(1, 0), 32'h0100_0123);
    rd_chk("R7 base copied to remap", ra(1, 2), 32'h0000_0123);
    rd_chk("R4 swap field kept", ra(1, 0), 32'h0100_0123);
    wr(ra(1, 1), 32'h1);
    wr(ra(1, 2), 32'h8000);
    wr(ra(1, 3), 32'h2);
    look("R6 mem translate", 36'h0_0123_4567, 1'b1, 4'd1, 64'h2_8000_4567);
    look("R5 last byte", 36'h0_0124_FFFF, 1'b1, 4'd1, 64'h2_8001_FFFF);
    look("R5 past end", 36'h0_0125_0000, 1'b0, 4'hF, 64'h0);
    look("R5 before start", 36'h0_0122_FFFF, 1'b0, 4'hF, 64'h0);
  endtask

  task automatic t_cfg;
    wr(A_CFG, 32'h0800_0000);
    rd_chk("R7 cfg readback", A_CFG, 32'h0800_0000);
    wr(ra(2, 0), 32'h0000_0456);
    rd_chk("R7 copy blocked", ra(2, 2), 32'h0);
    wr(A_CFG, 32'h0);
    wr(ra(2, 0), 32'h0000_0789);
    rd_chk("R7 copy restored", ra(2, 2), 32'h0000_0789);
  endtask

  task automatic t_high;
    wr(A_EN, 32'h001F_F7FF);
    wr(ra(2, 0), 32'h000F_0000);
    wr(ra(2, 1), 32'h0);
    wr(ra(2, 3), 32'h0);
    look("R12 above 4 GiB", 36'hF_0000_0010, 1'b1, 4'd2, 64'h10);
    look("R12 no alias", 36'h0_0000_0010, 1'b0, 4'hF, 64'h0);
  endtask

  task automatic t_overlap;
    wr(ra(1, 0), 32'h0000_0123);
    wr(ra(1, 3), 32'h0);
    wr(ra(3, 0), 32'h0000_0123);
    wr(ra(3, 1), 32'h1);
    wr(ra(3, 2), 32'h0);
    wr(A_EN, 32'h001F_EBFF);
    look("R10 overlap lower wins", 36'h0_0123_0000, 1'b1, 4'd1, 64'h0123_0000);
    wr(A_EN, 32'h001F_EFFF);
    look("R2 R10 lower disabled", 36'h0_0123_0008, 1'b1, 4'd3, 64'h8);
  endtask

  task automatic t_io;
    wr(ra(0, 3), 32'hFFFF_FFFF);
    rd_chk("R8 io high remap", ra(0, 3), 32'h0);
    wr(ra(0, 0), 32'h0000_0200);
    wr(ra(0, 1), 32'h0);
    wr(A_EN, 32'h001F_FDFF);
    look("R8 io translate", 36'h0_0200_0044, 1'b1, 4'd0, 64'h0000_0000_0200_0044);
  endtask

  task automatic t_regwin;
    wr(ra(10, 2), 32'h1234);
    rd_chk("R9 regs remap ignored", ra(10, 2), 32'h0);
    wr(ra(10, 1), 32'hFF);
    rd_chk("R9 regs size ignored", ra(10, 1), 32'h0);
    wr(ra(10, 0), 32'h0000_0ABC);
    wr(A_EN, 32'h000F_FFFF);
    look("R9 regs translate", 36'h0_0ABC_0010, 1'b1, 4'd10, 64'h10);
    look("R9 regs fixed 64K", 36'h0_0ABD_0000, 1'b0, 4'hF, 64'h0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; lk_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_masks();
    t_enable();
    t_mem();
    t_cfg();
    t_high();
    t_overlap();
    t_io();
    t_regwin();
    summary();
    $finish;
  end

endmodule